// File: doc/BRIEF.md
# Branch Target Two-Word Fetch Cache

The block sits beside a fetch unit that reads 16-bit instruction words. It remembers the address of the last cacheable jump that was taken, along with that jump's target A and the two words stored at A and A+2. When the same jump is taken again and the entry is still valid, the block presents both words at once, and the fetch unit continues reading memory from A+4. Because a double-word instruction at the target arrives whole from the cache, the memory round trip after a jump is hidden.

The block also keeps the fetch address. A taken jump redirects it. Each memory return that is accepted moves it forward by one word. When the transfer engine takes the bus and raises the stall input, the address is frozen and any returns during the stall are ignored. A stall that falls right after a jump therefore cannot cause a word to be fetched twice. Far control transfers and an explicit invalidate input empty the cache.

Top module: `branch_word_cache`

## Requirements
- R1: While and after reset, `hit` is 0, `fetch_addr` equals the parameter RESET_ADDR and the cache is empty, so the first jump after reset misses.
- R2: `jmp_kind` codes 3'd0 (relative), 3'd1 (absolute conditional) and 3'd2 (bit test) are cacheable. When such a jump is taken and misses, in the next cycle `hit` is 0 and `fetch_addr` equals the target. Cached entries for all three kinds hit.
- R3: After a miss, the next two accepted memory returns are stored as the words at the target and at target+2. Accepted means `mem_rvalid`=1 with `xfer_stall`=0 and no jump or invalidate in that cycle. The entry becomes valid only once both words are stored.
- R4: A taken cacheable jump whose address and target both match a valid entry gives, in the next cycle, `hit`=1 for one cycle, `hit_word0`/`hit_word1` equal to the stored words, and `fetch_addr` equal to target+4.
- R5: A taken jump with code 3'd3 (segment jump) never hits and never fills. It empties the cache and sets `fetch_addr` to its target.
- R6: `far_evt` (far call, far return, trap, interrupt entry or return) empties the cache in the same cycle. A jump in that same cycle does not hit and does not start a fill.
- R7: The synchronous `inv` input behaves exactly like `far_evt` with respect to the cache.
- R8: A taken jump with code 3'd4 (indirect) or any code from 3'd5 to 3'd7 redirects `fetch_addr` to its target. It neither fills nor hits and leaves a valid entry intact.
- R9: While `xfer_stall`=1 and no jump is taken, `fetch_addr` holds and returns are ignored. After a hit, the following accepted returns advance `fetch_addr` from target+4 to target+6 and beyond, with no repeat of target+2.
- R10: A taken jump during a fill abandons that fill, and the abandoned entry never hits.
- R11: `hit_word0` and `hit_word1` change only in a cycle where `hit`=1 and hold their values between hits.
- R12: A cacheable jump from a different address or to a different target misses and replaces the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| jmp_taken | input | 1 | A jump is taken this cycle |
| jmp_kind | input | 3 | Jump class code (see R2, R5, R8) |
| jmp_pc | input | ADDR_W | Address of the jump instruction |
| jmp_tgt | input | ADDR_W | Jump target address |
| mem_rvalid | input | 1 | Memory returned the word at `fetch_addr` |
| mem_rdata | input | WORD_W | Returned instruction word |
| xfer_stall | input | 1 | Transfer engine owns the bus this cycle |
| far_evt | input | 1 | Far control transfer or interrupt event |
| inv | input | 1 | Synchronous invalidate |
| hit | output | 1 | Cached target words are valid this cycle |
| hit_word0 | output | WORD_W | Word at target |
| hit_word1 | output | WORD_W | Word at target+2 |
| fetch_addr | output | ADDR_W | Next address for the fetch unit to read |

## Verification
A wrong valid bit or a wrong tag shows up as `hit` at the wrong time: a false hit or a lost hit appears one cycle after the jump that tests it. A fill index that moves during a stall shows up as a wrong `hit_word1`, and it does so only at the next matching jump, which may be many cycles later. The bench therefore replays each fill and then hits on it. A fetch address that moves during a stall differs from the model on the very next cycle, and a replay of target+2 shows as target+2 instead of target+6 after the first accepted return following a hit.

// File: rtl/btc_pkg.sv
package btc_pkg;
  localparam int BTC_WORDS = 2;
  localparam int BTC_IDX_W = $clog2(BTC_WORDS);

  typedef enum logic [2:0] {
    JK_REL      = 3'd0,
    JK_ABS_COND = 3'd1,
    JK_BIT_TEST = 3'd2,
    JK_SEGMENT  = 3'd3,
    JK_INDIRECT = 3'd4
  } jkind_e;

  function automatic logic kind_cacheable(input logic [2:0] k);
    return (k == JK_REL) || (k == JK_ABS_COND) || (k == JK_BIT_TEST);
  endfunction

  function automatic logic kind_far(input logic [2:0] k);
    return k == JK_SEGMENT;
  endfunction
endpackage

// File: rtl/btc_tag.sv
module btc_tag
  import btc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 jmp_taken,
  input  logic [2:0]           jmp_kind,
  input  logic [ADDR_W-1:0]    jmp_pc,
  input  logic [ADDR_W-1:0]    jmp_tgt,
  input  logic                 mem_rvalid,
  input  logic                 xfer_stall,
  input  logic                 far_evt,
  input  logic                 inv,
  output logic                 lookup_hit,
  output logic                 hit,
  output logic                 wr_en,
  output logic [BTC_IDX_W-1:0] wr_idx
);
  logic                 valid;
  logic                 filling;
  logic [BTC_IDX_W-1:0] fill_idx;
  logic [ADDR_W-1:0]    tag_pc;
  logic [ADDR_W-1:0]    tag_tgt;
  logic                 kill;
  logic                 cacheable;
  logic                 last_word;

  assign kill       = far_evt | inv;
  assign cacheable  = kind_cacheable(jmp_kind);
  assign lookup_hit = jmp_taken && cacheable && !kill && valid &&
                      (tag_pc == jmp_pc) && (tag_tgt == jmp_tgt);
  assign wr_en      = filling && !kill && !jmp_taken && mem_rvalid && !xfer_stall;
  assign wr_idx     = fill_idx;
  assign last_word  = fill_idx == BTC_IDX_W'(BTC_WORDS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= 1'b0;
      filling  <= 1'b0;
      fill_idx <= '0;
      tag_pc   <= '0;
      tag_tgt  <= '0;
      hit      <= 1'b0;
    end else begin
      hit <= lookup_hit;
      if (kill) begin
        valid   <= 1'b0;
        filling <= 1'b0;
      end else if (jmp_taken) begin
        if (cacheable) begin
          if (!lookup_hit) begin
            valid    <= 1'b0;
            filling  <= 1'b1;
            fill_idx <= '0;
            tag_pc   <= jmp_pc;
            tag_tgt  <= jmp_tgt;
          end
        end else begin
          filling <= 1'b0;
          if (kind_far(jmp_kind)) valid <= 1'b0;
        end
      end else if (wr_en) begin
        fill_idx <= fill_idx + 1'b1;
        if (last_word) begin
          filling <= 1'b0;
          valid   <= 1'b1;
        end
      end
    end
  end

  // R3: the entry turns valid only on an accepted return during a fill
  a_r3_valid_from_fill: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(filling) && $past(mem_rvalid) && !$past(xfer_stall));

  // R6 and R7: kill events leave the cache empty and give no hit
  a_r6_kill_empties: assert property (@(posedge clk) disable iff (rst)
    (far_evt || inv) |=> !valid && !hit);

  a_r4_hit_origin: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(jmp_taken) && $past(valid));

  a_r10_jump_ends_fill: assert property (@(posedge clk) disable iff (rst)
    (jmp_taken && !kind_cacheable(jmp_kind)) |=> !filling);

  a_r5_segment_empties: assert property (@(posedge clk) disable iff (rst)
    (jmp_taken && kind_far(jmp_kind)) |=> !valid);
endmodule

// File: rtl/btc_words.sv
module btc_words
  import btc_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [BTC_IDX_W-1:0] wr_idx,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic                 rd_en,
  output logic [WORD_W-1:0]    rd_w0,
  output logic [WORD_W-1:0]    rd_w1
);
  logic [WORD_W-1:0] mem [BTC_WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_w0 <= '0;
      rd_w1 <= '0;
    end else if (rd_en) begin
      rd_w0 <= mem[0];
      rd_w1 <= mem[1];
    end
  end

  // R11: output words move only on a lookup hit
  a_r11_words_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_w0) && $stable(rd_w1));
endmodule

// File: rtl/btc_fetch.sv
module btc_fetch #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              jmp_taken,
  input  logic [ADDR_W-1:0] jmp_tgt,
  input  logic              lookup_hit,
  input  logic              mem_rvalid,
  input  logic              xfer_stall,
  output logic [ADDR_W-1:0] fetch_addr
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] SKIP_STEP = ADDR_W'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_addr <= RESET_ADDR;
    end else if (jmp_taken) begin
      fetch_addr <= lookup_hit ? jmp_tgt + SKIP_STEP : jmp_tgt;
    end else if (mem_rvalid && !xfer_stall) begin
      fetch_addr <= fetch_addr + WORD_STEP;
    end
  end

  // R9: a stall freezes the fetch address
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (xfer_stall && !jmp_taken) |=> $stable(fetch_addr));

  a_r2_redirect: assert property (@(posedge clk) disable iff (rst)
    (jmp_taken && !lookup_hit) |=> fetch_addr == $past(jmp_tgt));
endmodule

// File: rtl/branch_word_cache.sv
module branch_word_cache
  import btc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              jmp_taken,
  input  logic [2:0]        jmp_kind,
  input  logic [ADDR_W-1:0] jmp_pc,
  input  logic [ADDR_W-1:0] jmp_tgt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              xfer_stall,
  input  logic              far_evt,
  input  logic              inv,
  output logic              hit,
  output logic [WORD_W-1:0] hit_word0,
  output logic [WORD_W-1:0] hit_word1,
  output logic [ADDR_W-1:0] fetch_addr
);
  logic                 lookup_hit;
  logic                 wr_en;
  logic [BTC_IDX_W-1:0] wr_idx;

  btc_tag #(.ADDR_W(ADDR_W)) u_tag (
    .clk        (clk),
    .rst        (rst),
    .jmp_taken  (jmp_taken),
    .jmp_kind   (jmp_kind),
    .jmp_pc     (jmp_pc),
    .jmp_tgt    (jmp_tgt),
    .mem_rvalid (mem_rvalid),
    .xfer_stall (xfer_stall),
    .far_evt    (far_evt),
    .inv        (inv),
    .lookup_hit (lookup_hit),
    .hit        (hit),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx)
  );

  btc_words #(.WORD_W(WORD_W)) u_words (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (mem_rdata),
    .rd_en   (lookup_hit),
    .rd_w0   (hit_word0),
    .rd_w1   (hit_word1)
  );

  btc_fetch #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .jmp_taken  (jmp_taken),
    .jmp_tgt    (jmp_tgt),
    .lookup_hit (lookup_hit),
    .mem_rvalid (mem_rvalid),
    .xfer_stall (xfer_stall),
    .fetch_addr (fetch_addr)
  );

  // R4: a hit always resumes two words past the target
  a_r4_resume_past_pair: assert property (@(posedge clk) disable iff (rst)
    hit |-> fetch_addr == ADDR_W'($past(jmp_tgt) + ADDR_W'(4)));

  // R8: an indirect jump never produces a hit
  a_r8_indirect_no_hit: assert property (@(posedge clk) disable iff (rst)
    (jmp_taken && jmp_kind >= 3'd4) |=> !hit);
endmodule

// File: tb/tb_branch_word_cache.sv
module tb_branch_word_cache;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        jmp_taken = 1'b0;
  logic [2:0]  jmp_kind = 3'd0;
  logic [15:0] jmp_pc = '0;
  logic [15:0] jmp_tgt = '0;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        xfer_stall = 1'b0;
  logic        far_evt = 1'b0;
  logic        inv = 1'b0;
  logic        hit;
  logic [15:0] hit_word0, hit_word1, fetch_addr;

  int checks = 0;
  int failures = 0;

  branch_word_cache dut (
    .clk(clk), .rst(rst), .jmp_taken(jmp_taken), .jmp_kind(jmp_kind),
    .jmp_pc(jmp_pc), .jmp_tgt(jmp_tgt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .xfer_stall(xfer_stall), .far_evt(far_evt),
    .inv(inv), .hit(hit), .hit_word0(hit_word0), .hit_word1(hit_word1),
    .fetch_addr(fetch_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  bit          m_valid, m_filling, e_hit;
  logic [15:0] m_pc, m_tgt, e_w0, e_w1, e_fa;
  logic [15:0] m_q[$];

  always @(posedge clk) begin
    if (rst) begin
      m_valid = 0; m_filling = 0; e_hit = 0;
      e_w0 = 0; e_w1 = 0; e_fa = 0; m_q.delete();
    end else begin
      bit kill, cach, h;
      kill = far_evt || inv;
      cach = jmp_kind <= 3'd2;
      h = jmp_taken && cach && !kill && m_valid && jmp_pc == m_pc && jmp_tgt == m_tgt;
      e_hit = h;
      if (h) begin e_w0 = m_q[0]; e_w1 = m_q[1]; end
      if (jmp_taken) e_fa = h ? jmp_tgt + 16'd4 : jmp_tgt;
      else if (mem_rvalid && !xfer_stall) e_fa = e_fa + 16'd2;
      if (kill) begin
        m_valid = 0; m_filling = 0;
      end else if (jmp_taken) begin
        if (cach) begin
          if (!h) begin
            m_valid = 0; m_filling = 1; m_pc = jmp_pc; m_tgt = jmp_tgt; m_q.delete();
          end
        end else begin
          m_filling = 0;
          if (jmp_kind == 3'd3) m_valid = 0;
        end
      end else if (m_filling && mem_rvalid && !xfer_stall) begin
        m_q.push_back(mem_rdata);
        if (m_q.size() == 2) begin m_filling = 0; m_valid = 1; end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R4 model hit", {31'd0, hit}, {31'd0, e_hit});
      chk("R9 model fetch_addr", {16'd0, fetch_addr}, {16'd0, e_fa});
      chk("R11 model word0", {16'd0, hit_word0}, {16'd0, e_w0});
      chk("R11 model word1", {16'd0, hit_word1}, {16'd0, e_w1});
    end
  end

  task automatic cyc(input bit jt, input logic [2:0] k, input logic [15:0] pc,
                     input logic [15:0] tgt, input bit rv, input logic [15:0] d,
                     input bit st, input bit fe, input bit iv);
    jmp_taken = jt; jmp_kind = k; jmp_pc = pc; jmp_tgt = tgt;
    mem_rvalid = rv; mem_rdata = d; xfer_stall = st; far_evt = fe; inv = iv;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic jmp(input logic [2:0] k, input logic [15:0] pc, input logic [15:0] tgt);
    cyc(1, k, pc, tgt, 0, 0, 0, 0, 0);
  endtask
  task automatic ret(input logic [15:0] d); cyc(0, 0, 0, 0, 1, d, 0, 0, 0); endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle();
    chk("R1 reset hit", {31'd0, hit}, 32'd0);
    chk("R1 reset fetch", {16'd0, fetch_addr}, 32'h0);

    jmp(3'd0, 16'h0100, 16'h0200);
    chk("R2 miss hit", {31'd0, hit}, 32'd0);
    chk("R2 miss fetch", {16'd0, fetch_addr}, 32'h0200);
    cyc(0, 0, 0, 0, 1, 16'hDEAD, 1, 0, 0);
    chk("R9 stall holds", {16'd0, fetch_addr}, 32'h0200);
    ret(16'h1111);
    ret(16'h2222);
    chk("R3 fill advance", {16'd0, fetch_addr}, 32'h0204);
    idle();
    jmp(3'd0, 16'h0100, 16'h0200);
    chk("R4 hit", {31'd0, hit}, 32'd1);
    chk("R4 word0", {16'd0, hit_word0}, 32'h1111);
    chk("R4 word1", {16'd0, hit_word1}, 32'h2222);
    chk("R4 fetch", {16'd0, fetch_addr}, 32'h0204);
    cyc(0, 0, 0, 0, 1, 16'hBEEF, 1, 0, 0);
    chk("R11 hit one cycle", {31'd0, hit}, 32'd0);
    chk("R11 word hold", {16'd0, hit_word1}, 32'h2222);
    chk("R9 stall after hit", {16'd0, fetch_addr}, 32'h0204);
    ret(16'h7777);
    chk("R9 no replay", {16'd0, fetch_addr}, 32'h0206);

    jmp(3'd4, 16'h0400, 16'h0500);
    chk("R8 indirect fetch", {16'd0, fetch_addr}, 32'h0500);
    ret(16'h9999);
    jmp(3'd0, 16'h0100, 16'h0200);
    chk("R8 entry kept", {31'd0, hit}, 32'd1);

    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);
    jmp(3'd0, 16'h0100, 16'h0200);
    chk("R6 far event miss", {31'd0, hit}, 32'd0);
    ret(16'h3333);
    cyc(0, 0, 0, 0, 1, 16'hAAAA, 1, 0, 0);
    ret(16'h4444);
    jmp(3'd0, 16'h0100, 16'h0200);
    chk("R3 refill word0", {16'd0, hit_word0}, 32'h3333);
    chk("R3 refill word1", {16'd0, hit_word1}, 32'h4444);

    cyc(1, 3'd0, 16'h0100, 16'h0200, 0, 0, 0, 0, 1);
    chk("R7 inv same cycle", {31'd0, hit}, 32'd0);
    chk("R7 inv fetch", {16'd0, fetch_addr}, 32'h0200);
    ret(16'h5555); ret(16'h6666);
    jmp(3'd0, 16'h0100, 16'h0200);
    chk("R7 no fill after inv", {31'd0, hit}, 32'd0);
    ret(16'h5555); ret(16'h6666);

    jmp(3'd3, 16'h0110, 16'h0800);
    chk("R5 segment fetch", {16'd0, fetch_addr}, 32'h0800);
    jmp(3'd0, 16'h0100, 16'h0200);
    chk("R5 emptied", {31'd0, hit}, 32'd0);
    ret(16'h1212);
    jmp(3'd5, 16'h0120, 16'h0900);
    ret(16'h3434);
    jmp(3'd0, 16'h0100, 16'h0200);
    chk("R10 abandoned fill", {31'd0, hit}, 32'd0);
    ret(16'h5656); ret(16'h7878);

    jmp(3'd1, 16'h0180, 16'h0200);
    chk("R12 other pc miss", {31'd0, hit}, 32'd0);
    ret(16'hA1A1); ret(16'hB2B2);
    jmp(3'd1, 16'h0180, 16'h0200);
    chk("R2 abs cond hit", {16'd0, hit_word0}, 32'hA1A1);
    jmp(3'd2, 16'h0180, 16'h0300);
    chk("R12 other target miss", {31'd0, hit}, 32'd0);
    ret(16'hC3C3); ret(16'hD4D4);
    jmp(3'd2, 16'h0180, 16'h0300);
    chk("R2 bit test hit", {16'd0, hit_word1}, 32'hD4D4);

    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 6) == 0, 3'($urandom % 6),
          ($urandom % 2) ? 16'h0100 : 16'h0180,
          ($urandom % 2) ? 16'h0200 : 16'h0300,
          ($urandom % 2) == 0, 16'($urandom), ($urandom % 5) == 0,
          ($urandom % 30) == 0, ($urandom % 30) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule